// File: doc/BRIEF.md
# Priority-Level Interrupt Controller

This block gathers a set of interrupt request lines (40 by default) and sorts them by a priority level that software assigns to each line. The level is a 5-bit value, so there are 32 levels: level 31 is the most urgent and level 0 the least. Every line whose request is active, whether it comes from the input pin or from a software force bit, marks its level in a 32-bit pending-per-level vector.

Two masks, one for the fast class and one for the normal class, are applied to that vector and the results are registered. Each class drives an active-low request output. The fast class takes precedence: while a fast request is active, the normal request is held inactive. A single 5-bit vector output gives the highest pending level of the winning class, or 0 when nothing is pending.

Software reaches the level selects, the force bits and both masks through a small synchronous register port. Reads return data one cycle after the address is presented.

Top module: `lvl_irq_ctrl`

## Requirements
- R1: After reset every level select reads 0, both force registers and both masks read 0, `fast_req_n` and `norm_req_n` are 1, and `vec` is 0.
- R2: The register at address s (0 to NSRC-1) holds the level of source s in bits 4:0. An active source s sets bit level(s) of the per-level pending vector, which reads at address NSRC+6. Several sources on one level OR together.
- R3: Force bits OR with the source inputs before level mapping. Address NSRC bit i forces source i for i in 0..31. Address NSRC+1 bit i forces source 32+i. Clearing a force bit removes the forced request.
- R4: The fast pending register equals the fast mask ANDed with the per-level pending vector. The fast mask is at address NSRC+2, and the fast pending register reads at address NSRC+4.
- R5: `fast_req_n` is 0 exactly when the fast pending register is nonzero.
- R6: The normal pending register equals the normal mask ANDed with the per-level pending vector. The normal mask is at address NSRC+3, and the normal pending register reads at address NSRC+5. `norm_req_n` is 0 only when the normal pending register is nonzero and `fast_req_n` is 1.
- R7: `vec` is the index of the highest set bit of the fast pending register when `fast_req_n` is 0. Otherwise it is the highest set bit of the normal pending register when `norm_req_n` is 0. Otherwise it is 0.
- R8: A change on a source input shows on the outputs after the next rising clock edge. A register write commits on the edge where `reg_we` is sampled, and its effect on the outputs shows one edge later.
- R9: `reg_rdata` shows the register at the address sampled on the previous rising edge. Unused register bits read 0, and writes to the read-only addresses NSRC+4 to NSRC+6 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src | input | NSRC | Interrupt request lines, active high |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | AW | Register address |
| reg_wdata | input | DW | Register write data |
| reg_rdata | output | DW | Registered read data |
| fast_req_n | output | 1 | Fast request, active low |
| norm_req_n | output | 1 | Normal request, active low |
| vec | output | LW | Vector number of the winning class |

## Verification
The bench drives two sources that share a level, so a design that let one of them mask the other would lose the pending bit. It enables the same level in both masks to confirm that the normal request goes quiet behind a fast one. A design that ignored the precedence would assert both outputs and present the wrong vector. It places a normal request on level 0 to tell an active request with vector 0 apart from the idle state. It also forces a source in the upper force register, because a wrong bit offset there would raise a level that no source was assigned. Finally, it counts edges after source changes and after writes, and tries writes to the read-only addresses, to catch an extra pipeline stage or a writable status register.

// File: rtl/lvl_irq_ctrl.sv
module lvl_irq_ctrl #(
  parameter int NSRC = 40,
  parameter int NLVL = 32,
  parameter int DW   = 32,
  parameter int AW   = 6
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NSRC-1:0]          src,
  input  logic                     reg_we,
  input  logic [AW-1:0]            reg_addr,
  input  logic [DW-1:0]            reg_wdata,
  output logic [DW-1:0]            reg_rdata,
  output logic                     fast_req_n,
  output logic                     norm_req_n,
  output logic [$clog2(NLVL)-1:0]  vec
);
  localparam int LW   = $clog2(NLVL);
  localparam int FLW  = 32;
  localparam int FHW  = NSRC - FLW;
  localparam int A_FLO = NSRC;
  localparam int A_FHI = NSRC + 1;
  localparam int A_FEN = NSRC + 2;
  localparam int A_NEN = NSRC + 3;
  localparam int A_FPD = NSRC + 4;
  localparam int A_NPD = NSRC + 5;
  localparam int A_LPD = NSRC + 6;

  logic [LW-1:0]   lvl_q [NSRC];
  logic [NSRC-1:0] force_q;
  logic [NLVL-1:0] fen_q, nen_q;
  logic [NLVL-1:0] lvl_pend, fast_pend, norm_pend;
  logic [NSRC-1:0] req;
  logic [DW-1:0]   rd_mux;
  int              addr_i;

  function automatic logic [LW-1:0] top_bit(input logic [NLVL-1:0] v);
    logic [LW-1:0] idx;
    idx = '0;
    for (int i = 0; i < NLVL; i++)
      if (v[i]) idx = LW'(i);
    return idx;
  endfunction

  assign req    = src | force_q;
  assign addr_i = int'(reg_addr);

  always_comb begin
    lvl_pend = '0;
    for (int s = 0; s < NSRC; s++)
      if (req[s]) lvl_pend[lvl_q[s]] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < NSRC; s++) lvl_q[s] <= '0;
      force_q <= '0;
      fen_q   <= '0;
      nen_q   <= '0;
    end else if (reg_we) begin
      if (addr_i < NSRC) lvl_q[addr_i] <= reg_wdata[LW-1:0];
      else if (addr_i == A_FLO) force_q[FLW-1:0] <= reg_wdata[FLW-1:0];
      else if (addr_i == A_FHI) force_q[NSRC-1:FLW] <= reg_wdata[FHW-1:0];
      else if (addr_i == A_FEN) fen_q <= reg_wdata[NLVL-1:0];
      else if (addr_i == A_NEN) nen_q <= reg_wdata[NLVL-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fast_pend <= '0;
      norm_pend <= '0;
    end else begin
      fast_pend <= fen_q & lvl_pend;
      norm_pend <= nen_q & lvl_pend;
    end
  end

  always_comb begin
    rd_mux = '0;
    if (addr_i < NSRC) rd_mux[LW-1:0] = lvl_q[addr_i];
    else if (addr_i == A_FLO) rd_mux[FLW-1:0] = force_q[FLW-1:0];
    else if (addr_i == A_FHI) rd_mux[FHW-1:0] = force_q[NSRC-1:FLW];
    else if (addr_i == A_FEN) rd_mux[NLVL-1:0] = fen_q;
    else if (addr_i == A_NEN) rd_mux[NLVL-1:0] = nen_q;
    else if (addr_i == A_FPD) rd_mux[NLVL-1:0] = fast_pend;
    else if (addr_i == A_NPD) rd_mux[NLVL-1:0] = norm_pend;
    else if (addr_i == A_LPD) rd_mux[NLVL-1:0] = lvl_pend;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) reg_rdata <= '0;
    else        reg_rdata <= rd_mux;
  end

  assign fast_req_n = ~|fast_pend;
  assign norm_req_n = ~(|norm_pend & fast_req_n);
  assign vec = !fast_req_n ? top_bit(fast_pend) :
               !norm_req_n ? top_bit(norm_pend) : '0;
endmodule

// File: rtl/lvl_irq_ctrl_chk.sv
module lvl_irq_ctrl_chk #(
  parameter int NLVL = 32
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    fast_req_n,
  input logic                    norm_req_n,
  input logic [$clog2(NLVL)-1:0] vec,
  input logic [NLVL-1:0]         fen_q,
  input logic [NLVL-1:0]         nen_q,
  input logic [NLVL-1:0]         lvl_pend,
  input logic [NLVL-1:0]         fast_pend,
  input logic [NLVL-1:0]         norm_pend
);
  assert_fast_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fast_req_n == ($past(fen_q & lvl_pend) == '0));

  assert_fast_mask_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fast_pend == $past(fen_q & lvl_pend));

  assert_norm_mask_R6: assert property (@(posedge clk) disable iff (!rst_n)
    norm_pend == $past(nen_q & lvl_pend));

  assert_norm_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !fast_req_n |-> norm_req_n);

  assert_vec_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (fast_req_n && norm_req_n) |-> vec == '0);

  assert_vec_fast_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !fast_req_n |-> (fast_pend >> vec) == NLVL'(1));

  assert_vec_norm_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (fast_req_n && !norm_req_n) |-> (norm_pend >> vec) == NLVL'(1));
endmodule

bind lvl_irq_ctrl lvl_irq_ctrl_chk #(.NLVL(NLVL)) u_chk (
  .clk(clk), .rst_n(rst_n), .fast_req_n(fast_req_n), .norm_req_n(norm_req_n),
  .vec(vec), .fen_q(fen_q), .nen_q(nen_q), .lvl_pend(lvl_pend),
  .fast_pend(fast_pend), .norm_pend(norm_pend)
);

// File: tb/sim_lvl_irq_ctrl.sv
module sim_lvl_irq_ctrl;
  localparam int NSRC = 40;
  localparam int NLVL = 32;
  localparam int DW = 32;
  localparam int AW = 6;
  localparam int LW = 5;
  localparam int NVEC = 8;

  typedef struct packed {
    logic [NSRC-1:0] s;
    logic [NLVL-1:0] fe;
    logic [NLVL-1:0] ne;
  } vec_t;

  localparam vec_t TBL [NVEC] = '{
    '{40'h00_0000_0000, 32'hFFFF_FFFF, 32'hFFFF_FFFF},
    '{40'h00_0000_0001, 32'h0000_0000, 32'hFFFF_FFFF},
    '{40'h00_0000_0002, 32'h0000_0080, 32'h0000_0000},
    '{40'h00_8000_0006, 32'h0000_0080, 32'hFFFF_FFFF},
    '{40'h00_8000_0006, 32'h0000_0000, 32'hFFFF_FFFF},
    '{40'hFF_0000_0000, 32'h0000_4000, 32'h1000_0000},
    '{40'hFF_FFFF_FFFF, 32'h0000_0000, 32'h0000_0000},
    '{40'h00_0000_0010, 32'h1000_0000, 32'h1000_0000}
  };

  logic clk = 1'b0;
  logic rst_n;
  logic [NSRC-1:0] src;
  logic reg_we;
  logic [AW-1:0] reg_addr;
  logic [DW-1:0] reg_wdata;
  logic [DW-1:0] reg_rdata;
  logic fast_req_n, norm_req_n;
  logic [LW-1:0] vec;

  int n_chk = 0;
  int n_bad = 0;
  logic [LW-1:0] lvl_m [NSRC];
  logic [NSRC-1:0] frc_m;

  always #2 clk = ~clk;

  lvl_irq_ctrl #(.NSRC(NSRC), .NLVL(NLVL), .DW(DW), .AW(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .src(src), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .fast_req_n(fast_req_n),
    .norm_req_n(norm_req_n), .vec(vec)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [DW-1:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = AW'(a); reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input int a, output logic [DW-1:0] d);
    @(negedge clk);
    reg_addr = AW'(a);
    @(negedge clk);
    d = reg_rdata;
  endtask

  function automatic logic [NLVL-1:0] model_pend(input logic [NSRC-1:0] s);
    logic [NLVL-1:0] p = '0;
    for (int i = 0; i < NSRC; i++)
      if (s[i] | frc_m[i]) p[lvl_m[i]] = 1'b1;
    return p;
  endfunction

  function automatic logic [LW-1:0] hi(input logic [NLVL-1:0] v);
    logic [LW-1:0] r = '0;
    for (int i = 0; i < NLVL; i++) if (v[i]) r = LW'(i);
    return r;
  endfunction

  task automatic expect_out(input string tag, input logic [NSRC-1:0] s,
                            input logic [NLVL-1:0] fe, input logic [NLVL-1:0] ne);
    logic [NLVL-1:0] p, fp, np;
    logic ef, en;
    logic [LW-1:0] ev;
    p = model_pend(s); fp = p & fe; np = p & ne;
    ef = (fp == '0);
    en = !((np != '0) && ef);
    ev = !ef ? hi(fp) : !en ? hi(np) : '0;
    check({tag, " fast_req_n R5"}, 64'(fast_req_n), 64'(ef));
    check({tag, " norm_req_n R6"}, 64'(norm_req_n), 64'(en));
    check({tag, " vec R7"}, 64'(vec), 64'(ev));
  endtask

  initial begin
    #400000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [DW-1:0] d;
    logic [NLVL-1:0] p;
    rst_n = 1'b0; src = '0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
    frc_m = '0;
    for (int i = 0; i < NSRC; i++) lvl_m[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    check("R1 fast_req_n reset", 64'(fast_req_n), 64'd1);
    check("R1 norm_req_n reset", 64'(norm_req_n), 64'd1);
    check("R1 vec reset", 64'(vec), 64'd0);
    rd(0, d);  check("R1 level0 reset", 64'(d), 64'd0);
    rd(39, d); check("R1 level39 reset", 64'(d), 64'd0);
    rd(NSRC, d);   check("R1 force lo reset", 64'(d), 64'd0);
    rd(NSRC+1, d); check("R1 force hi reset", 64'(d), 64'd0);
    rd(NSRC+2, d); check("R1 fast mask reset", 64'(d), 64'd0);
    rd(NSRC+3, d); check("R1 normal mask reset", 64'(d), 64'd0);

    for (int i = 0; i < NSRC; i++) begin
      lvl_m[i] = LW'((i * 7) % 32);
      wr(i, DW'(lvl_m[i]));
    end
    rd(33, d); check("R9 level readback", 64'(d), 64'(lvl_m[33]));
    wr(5, 32'hFFFF_FFE3);
    rd(5, d); check("R9 unused level bits read 0", 64'(d), 64'h3);
    wr(5, DW'(lvl_m[5]));

    for (int k = 0; k < NVEC; k++) begin
      wr(NSRC+2, TBL[k].fe);
      wr(NSRC+3, TBL[k].ne);
      @(negedge clk); src = TBL[k].s;
      repeat (2) @(negedge clk);
      expect_out($sformatf("tbl%0d", k), TBL[k].s, TBL[k].fe, TBL[k].ne);
      p = model_pend(TBL[k].s);
      rd(NSRC+6, d); check($sformatf("tbl%0d R2 level pend", k), 64'(d), 64'(p));
      rd(NSRC+4, d); check($sformatf("tbl%0d R4 fast pend", k), 64'(d), 64'(p & TBL[k].fe));
      rd(NSRC+5, d); check($sformatf("tbl%0d R6 norm pend", k), 64'(d), 64'(p & TBL[k].ne));
    end

    src = '0;
    wr(NSRC+2, 32'h0);
    wr(NSRC+3, 32'hFFFF_FFFF);
    wr(35, 32'd31); lvl_m[35] = 5'd31;
    wr(NSRC+1, 32'h0000_0008); frc_m[35] = 1'b1;
    repeat (2) @(negedge clk);
    expect_out("R3 force hi src35", '0, 32'h0, 32'hFFFF_FFFF);
    check("R3 force hi vec 31", 64'(vec), 64'd31);
    rd(NSRC+1, d); check("R3 force hi readback", 64'(d), 64'h8);
    wr(NSRC+1, 32'h0); frc_m[35] = 1'b0;
    repeat (2) @(negedge clk);
    check("R3 force cleared", 64'(norm_req_n), 64'd1);
    wr(NSRC, 32'h8000_0000); frc_m[31] = 1'b1;
    repeat (2) @(negedge clk);
    check("R3 force lo src31 vec", 64'(vec), 64'(lvl_m[31]));
    wr(NSRC, 32'h0); frc_m[31] = 1'b0;
    repeat (2) @(negedge clk);

    @(negedge clk); src = 40'h1;
    check("R8 before edge", 64'(norm_req_n), 64'd1);
    @(negedge clk);
    check("R8 one edge after source", 64'(norm_req_n), 64'd0);
    check("R8 vec level 0 active", 64'(vec), 64'd0);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = AW'(0); reg_wdata = 32'd31;
    @(negedge clk); reg_we = 1'b0; lvl_m[0] = 5'd31;
    check("R8 write not yet visible", 64'(vec), 64'd0);
    @(negedge clk);
    check("R8 write visible next edge", 64'(vec), 64'd31);

    wr(NSRC+2, 32'h8000_0000);
    repeat (2) @(negedge clk);
    check("R6 normal suppressed by fast", 64'(norm_req_n), 64'd1);
    check("R5 fast asserted", 64'(fast_req_n), 64'd0);
    rd(NSRC+4, d);
    wr(NSRC+4, 32'h0); wr(NSRC+6, 32'h0);
    repeat (2) @(negedge clk);
    rd(NSRC+4, d); check("R9 read-only fast pend write ignored", 64'(d), 64'h8000_0000);
    check("R9 fast_req_n unchanged", 64'(fast_req_n), 64'd0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule